// File: doc/BRIEF.md
# Vectored Interrupt Controller with Global Enable

This block sits next to a small processor core and decides when the core is diverted into an interrupt handler. Sixteen event sources arrive in two groups of eight, one for external pins and one for timers. Each group has an 8-bit enable register and an 8-bit pending register. Events are captured in the pending register whether or not the source is enabled, so nothing is lost while a source is masked or interrupts are globally off.

A single global enable gates every request. Entering a handler clears the global enable in hardware. The core drives three command pulses: a set-enable, a clear-enable and a return. The return restores the global enable. Setting the global enable inside a handler is what allows nested entry. On entry the block pushes the core's current program counter into an external stack memory, moves its own stack pointer down and hands the core a vector address to jump to. On return it moves the stack pointer back up, reads the saved address and hands that to the core instead.

Top module: `irq_ctrl`

## Requirements
- R1: An entry clears the global enable, and the enable reads 0 in the cycle that entry is signalled. No further entry happens until the enable is set again.
- R2: A return pulse sets the global enable on the next edge. The stack pointer rises by PCB. Two edges after the pulse, pc_load is 1 with irq_ack at 0, and pc_value holds the stack word at the updated stack pointer.
- R3: Set-enable sets and clear-enable clears the global enable on the next edge. Clear beats set or return in the same cycle, and an entry beats all three.
- R4: The register port uses these addresses: 0 for the external enable mask, 2 for the timer enable mask, 1 for the external pending flags and 3 for the timer pending flags. A write to 0 or 2 replaces the mask. reg_rdata shows the addressed register one edge after the address is applied.
- R5: A 1 on any bit of ext_evt or tmr_evt at an edge sets the matching pending bit, whatever the mask and the global enable.
- R6: An entry happens at an edge only when some pending bit, its mask bit and the global enable are all 1, and no return is in progress. In the following cycle irq_ack and pc_load are both 1 for one cycle.
- R7: Sources are numbered with external bit k as k and timer bit k as 8+k. The lowest-numbered enabled pending source wins, and its vector, (number+1)*VEC_STEP, appears on pc_value with irq_ack.
- R8: The pending bit of the winning source clears when it is taken. Writing 1s to address 1 or 3 clears those pending bits. A new event on the same edge keeps its bit set.
- R9: In the cycle irq_ack is 1, stk_we is 1, stk_addr holds the old stack pointer, stk_wdata holds the cpu_pc sampled at entry, and the stack pointer has dropped by PCB.
- R10: After reset the global enable, masks, flags, irq_ack, pc_load, stk_we and reg_rdata are 0, and stk_addr equals SP_INIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_evt | input | GW | External event strobes |
| tmr_evt | input | GW | Timer event strobes |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | GW | Register write data |
| reg_rdata | output | GW | Registered read data |
| cpu_sei | input | 1 | Set global enable |
| cpu_cli | input | 1 | Clear global enable |
| cpu_reti | input | 1 | Return from handler |
| cpu_pc | input | PCW | Current program counter |
| gie | output | 1 | Global enable state |
| irq_ack | output | 1 | Entry taken this cycle |
| pc_load | output | 1 | Core must load pc_value |
| pc_value | output | PCW | Vector or return address |
| stk_we | output | 1 | Stack write strobe |
| stk_addr | output | SPW | Stack address for push or pop |
| stk_wdata | output | PCW | Return address being pushed |
| stk_rdata | input | PCW | Stack word at stk_addr |

## Verification
A wrong pending or mask bit appears at the read port one edge after the address is applied. Within two edges it also appears as a missing, extra or wrongly vectored entry on irq_ack and pc_value. A wrong global enable shows directly on gie, and at the next pending event it shows as an entry that fires or fails to fire. A wrong stack pointer is seen at the next push on stk_addr. At the following return it is seen as a wrong address on pc_value.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // register select: bit 1 = group (0 ext, 1 timer), bit 0 = 1 for pending flags
  typedef enum logic [1:0] {
    RSEL_EXT_MASK = 2'd0,
    RSEL_EXT_FLAG = 2'd1,
    RSEL_TMR_MASK = 2'd2,
    RSEL_TMR_FLAG = 2'd3
  } rsel_e;

  localparam int unsigned N_GROUPS = 2;
endpackage

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic         mask_we,
  input  logic         flag_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] ack_clr,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] flag_q
);
  logic [W-1:0] sw_clr;
  assign sw_clr = flag_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      flag_q <= '0;
    end else begin
      if (mask_we) mask_q <= wdata;
      flag_q <= (flag_q & ~sw_clr & ~ack_clr) | evt;
    end
  end

  // every strobed event is held in the pending register
  assert_evt_latched_R5: assert property (@(posedge clk) disable iff (rst)
    (evt != '0) |=> ((flag_q & $past(evt)) == $past(evt)));

  // a masked source never changes its mask bit by itself
  assert_mask_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !mask_we |=> $stable(mask_q));
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = 4
) (
  input  logic [N-1:0]  req,
  output logic          valid,
  output logic [IW-1:0] idx
);
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        valid = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int unsigned GW       = 8,
  parameter int unsigned PCW      = 12,
  parameter int unsigned SPW      = 8,
  parameter int unsigned PCB      = 2,
  parameter int unsigned VEC_STEP = 1,
  parameter logic [7:0]  SP_INIT  = 8'hFF
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [GW-1:0]  ext_evt,
  input  logic [GW-1:0]  tmr_evt,
  input  logic           reg_we,
  input  logic [1:0]     reg_addr,
  input  logic [GW-1:0]  reg_wdata,
  output logic [GW-1:0]  reg_rdata,
  input  logic           cpu_sei,
  input  logic           cpu_cli,
  input  logic           cpu_reti,
  input  logic [PCW-1:0] cpu_pc,
  output logic           gie,
  output logic           irq_ack,
  output logic           pc_load,
  output logic [PCW-1:0] pc_value,
  output logic           stk_we,
  output logic [SPW-1:0] stk_addr,
  output logic [PCW-1:0] stk_wdata,
  input  logic [PCW-1:0] stk_rdata
);
  import irq_pkg::*;

  localparam int unsigned N  = N_GROUPS * GW;
  localparam int unsigned IW = $clog2(N);
  localparam logic [SPW-1:0] SP_RST  = SPW'(SP_INIT);
  localparam logic [SPW-1:0] SP_STEP = SPW'(PCB);

  logic [N_GROUPS-1:0][GW-1:0] evt_g, ack_g, mask_g, flag_g;
  logic [N-1:0]    pend, ack_vec;
  logic            win_vld, take, pop_q;
  logic [IW-1:0]   win_idx;
  logic [PCW-1:0]  vec;
  logic [SPW-1:0]  sp_q;
  logic            gie_q;

  assign evt_g = {tmr_evt, ext_evt};

  generate
    for (genvar g = 0; g < N_GROUPS; g++) begin : g_bank
      irq_bank #(.W(GW)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt_g[g]),
        .mask_we (reg_we && reg_addr[1] == 1'(g) && !reg_addr[0]),
        .flag_we (reg_we && reg_addr[1] == 1'(g) &&  reg_addr[0]),
        .wdata   (reg_wdata),
        .ack_clr (ack_g[g]),
        .mask_q  (mask_g[g]),
        .flag_q  (flag_g[g])
      );
    end
  endgenerate

  assign pend = flag_g & mask_g;

  irq_prio #(.N(N), .IW(IW)) u_prio (
    .req   (pend),
    .valid (win_vld),
    .idx   (win_idx)
  );

  assign take    = gie_q && win_vld && !cpu_reti && !pop_q;
  assign ack_vec = take ? (N'(1) << win_idx) : '0;
  assign ack_g   = ack_vec;
  assign vec     = PCW'(VEC_STEP) * (PCW'(win_idx) + PCW'(1));
  assign gie     = gie_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gie_q     <= 1'b0;
      sp_q      <= SP_RST;
      pop_q     <= 1'b0;
      irq_ack   <= 1'b0;
      pc_load   <= 1'b0;
      pc_value  <= '0;
      stk_we    <= 1'b0;
      stk_addr  <= SP_RST;
      stk_wdata <= '0;
      reg_rdata <= '0;
    end else begin
      irq_ack <= take;
      stk_we  <= take;
      pc_load <= take || pop_q;
      pop_q   <= cpu_reti;

      if (take)                    gie_q <= 1'b0;
      else if (cpu_cli)            gie_q <= 1'b0;
      else if (cpu_sei || cpu_reti) gie_q <= 1'b1;

      if (take) begin
        sp_q      <= sp_q - SP_STEP;
        stk_addr  <= sp_q;
        stk_wdata <= cpu_pc;
        pc_value  <= vec;
      end else if (cpu_reti) begin
        sp_q     <= sp_q + SP_STEP;
        stk_addr <= sp_q + SP_STEP;
      end

      if (pop_q) pc_value <= stk_rdata;

      reg_rdata <= reg_addr[0] ? flag_g[reg_addr[1]] : mask_g[reg_addr[1]];
    end
  end

  // entry leaves the global enable off
  assert_take_clears_gie_R1: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> !gie);

  assert_no_back_to_back_R1: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !irq_ack);

  assert_reti_sets_gie_R2: assert property (@(posedge clk) disable iff (rst)
    (cpu_reti && !cpu_cli) |=> gie);

  assert_pop_loads_R2: assert property (@(posedge clk) disable iff (rst)
    pop_q |=> (pc_load && !irq_ack));

  assert_cli_wins_R3: assert property (@(posedge clk) disable iff (rst)
    cpu_cli |=> !gie);

  assert_entry_gated_R6: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> (pc_load && $past(gie)));

  assert_lowest_wins_R7: assert property (@(posedge clk) disable iff (rst)
    win_vld |-> (pend[win_idx] && ((pend & ((N'(1) << win_idx) - N'(1))) == '0)));

  assert_push_R9: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> (stk_we && sp_q == stk_addr - SP_STEP));
endmodule

// File: tb/test_irq_ctrl.sv
`timescale 1ns/1ps
module test_irq_ctrl;
  localparam int GW = 8, PCW = 12, SPW = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic [GW-1:0] ext_evt = '0, tmr_evt = '0, reg_wdata = '0, reg_rdata;
  logic reg_we = 1'b0, cpu_sei = 1'b0, cpu_cli = 1'b0, cpu_reti = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [PCW-1:0] cpu_pc = '0, pc_value, stk_wdata, stk_rdata;
  logic gie, irq_ack, pc_load, stk_we;
  logic [SPW-1:0] stk_addr;
  logic [PCW-1:0] mem [256];

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_ctrl i_irq_ctrl (
    .clk(clk), .rst(rst), .ext_evt(ext_evt), .tmr_evt(tmr_evt),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_sei(cpu_sei), .cpu_cli(cpu_cli), .cpu_reti(cpu_reti), .cpu_pc(cpu_pc),
    .gie(gie), .irq_ack(irq_ack), .pc_load(pc_load), .pc_value(pc_value),
    .stk_we(stk_we), .stk_addr(stk_addr), .stk_wdata(stk_wdata), .stk_rdata(stk_rdata)
  );

  // external stack memory
  assign stk_rdata = mem[stk_addr];
  always @(posedge clk) if (stk_we) mem[stk_addr] <= stk_wdata;

  // reference model state
  logic [7:0] m_em, m_ef, m_tm, m_tf, m_sp, m_addr, e_rd;
  logic m_gie, m_pop, e_ack, e_load, e_we;
  logic [PCW-1:0] m_stk [256];
  logic [PCW-1:0] e_pcv, e_wdata;
  int depth;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int lowest(input logic [15:0] v);
    for (int i = 0; i < 16; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic model_reset();
    m_em = 0; m_ef = 0; m_tm = 0; m_tf = 0; m_sp = 8'hFF; m_addr = 8'hFF;
    m_gie = 0; m_pop = 0; e_ack = 0; e_load = 0; e_we = 0; e_rd = 0;
    e_pcv = 0; e_wdata = 0; depth = 0;
  endtask

  task automatic step(input logic [7:0] ee, input logic [7:0] te, input logic sei,
                      input logic cli, input logic reti, input logic we,
                      input logic [1:0] addr, input logic [7:0] wd, input logic [PCW-1:0] pc);
    logic [15:0] pend, ackv;
    logic take;
    int idx;
    logic [1:0] prev_addr;
    ext_evt = ee; tmr_evt = te; cpu_sei = sei; cpu_cli = cli; cpu_reti = reti;
    reg_we = we; reg_addr = addr; reg_wdata = wd; cpu_pc = pc;
    pend = {m_tf & m_tm, m_ef & m_em};
    take = m_gie && pend != 0 && !reti && !m_pop;
    idx  = lowest(pend);
    ackv = take ? (16'd1 << idx) : 16'd0;
    e_rd = addr[0] ? (addr[1] ? m_tf : m_ef) : (addr[1] ? m_tm : m_em);
    e_ack = take; e_we = take; e_load = take || m_pop;
    if (m_pop) e_pcv = m_stk[m_addr];
    if (take) begin
      e_pcv = PCW'(idx + 1); e_wdata = pc;
      m_stk[m_sp] = pc; m_addr = m_sp; m_sp = m_sp - 8'd2; depth++;
    end else if (reti) begin
      m_sp = m_sp + 8'd2; m_addr = m_sp; depth--;
    end
    m_pop = reti;
    m_ef = (m_ef & ~((we && addr == 2'd1) ? wd : 8'h0) & ~ackv[7:0]) | ee;
    m_tf = (m_tf & ~((we && addr == 2'd3) ? wd : 8'h0) & ~ackv[15:8]) | te;
    if (we && addr == 2'd0) m_em = wd;
    if (we && addr == 2'd2) m_tm = wd;
    if (take) m_gie = 0; else if (cli) m_gie = 0; else if (sei || reti) m_gie = 1;
    prev_addr = addr;
    @(posedge clk); @(negedge clk);
    chk("R1/R2/R3", "gie", gie, m_gie);
    chk("R6", "irq_ack", irq_ack, e_ack);
    chk("R6/R2", "pc_load", pc_load, e_load);
    if (e_load) chk(e_ack ? "R7" : "R2", "pc_value", pc_value, e_pcv);
    chk("R9", "stk_we", stk_we, e_we);
    if (e_we) begin
      chk("R9", "stk_addr", stk_addr, m_addr);
      chk("R9", "stk_wdata", stk_wdata, e_wdata);
    end
    chk(prev_addr[0] ? "R5/R8" : "R4", "reg_rdata", reg_rdata, e_rd);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 2'd0, 0, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R10 reset state
    chk("R10", "gie", gie, 0);
    chk("R10", "irq_ack", irq_ack, 0);
    chk("R10", "pc_load", pc_load, 0);
    chk("R10", "stk_we", stk_we, 0);
    chk("R10", "stk_addr", stk_addr, 8'hFF);
    chk("R10", "reg_rdata", reg_rdata, 0);

    // R4 mask write and read back
    step(0, 0, 0, 0, 0, 1, 2'd0, 8'hA5, 0);
    step(0, 0, 0, 0, 0, 1, 2'd2, 8'h3C, 0);
    step(0, 0, 0, 0, 0, 0, 2'd0, 0, 0);
    chk("R4", "ext mask", reg_rdata, 8'hA5);
    step(0, 0, 0, 0, 0, 0, 2'd2, 0, 0);
    chk("R4", "timer mask", reg_rdata, 8'h3C);

    // R5 masked event with gie off still latched, no entry
    step(8'h02, 8'h01, 0, 0, 0, 0, 2'd1, 0, 0);
    step(0, 0, 0, 0, 0, 0, 2'd1, 0, 0);
    chk("R5", "ext flag", reg_rdata, 8'h02);
    step(0, 0, 0, 0, 0, 0, 2'd3, 0, 0);
    chk("R5", "timer flag", reg_rdata, 8'h01);
    chk("R6", "no entry when masked", irq_ack, 0);

    // R8 write one to clear
    step(0, 0, 0, 0, 0, 1, 2'd1, 8'h02, 0);
    step(0, 0, 0, 0, 0, 1, 2'd3, 8'h01, 0);
    step(0, 0, 0, 0, 0, 0, 2'd1, 0, 0);
    chk("R8", "ext flag cleared", reg_rdata, 8'h00);

    // R3 clear beats set
    step(0, 0, 1, 1, 0, 0, 2'd0, 0, 0);
    chk("R3", "cli over sei", gie, 0);

    // R7 simultaneous sources: ext2, ext5, timer2 (masks A5/3C -> bits 0,2,5,7 and 2..5)
    step(8'h24, 8'h04, 0, 0, 0, 0, 2'd0, 0, 12'h123);
    step(0, 0, 1, 0, 0, 0, 2'd0, 0, 12'h456);
    step(0, 0, 0, 0, 0, 0, 2'd0, 0, 12'h789);
    chk("R7", "vector of ext bit 2", pc_value, 12'd3);
    chk("R1", "gie off at entry", gie, 0);
    idle(3);
    chk("R1", "no second entry", irq_ack, 0);
    step(0, 0, 0, 0, 1, 0, 2'd0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 2'd0, 0, 0);
    chk("R2", "return address", pc_value, 12'h789);
    step(0, 0, 0, 0, 0, 0, 2'd1, 0, 0);
    chk("R7", "next vector ext bit 5", pc_value, 12'd6);
    step(0, 0, 0, 0, 1, 0, 2'd1, 0, 0);
    idle(2);
    chk("R7", "timer bit 2 vector", pc_value, 12'd11);
    step(0, 0, 0, 0, 1, 0, 2'd0, 0, 0);
    idle(2);
    // R8 event on same edge as w1c survives
    step(8'h01, 0, 0, 0, 0, 1, 2'd1, 8'h01, 0);
    step(0, 0, 0, 0, 0, 0, 2'd1, 0, 0);
    chk("R8", "set wins over clear", reg_rdata, 8'h01);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] ee, te, wd;
      logic s, c, r, w;
      logic [1:0] a;
      ee = 8'($urandom & $urandom & $urandom);
      te = 8'($urandom & $urandom & $urandom);
      s  = ($urandom % 4) == 0;
      c  = ($urandom % 16) == 0;
      r  = depth > 0 && !m_pop && ($urandom % 5) == 0;
      w  = ($urandom % 8) == 0;
      a  = 2'($urandom);
      wd = 8'($urandom);
      step(ee, te, s, c, r, w, a, wd, PCW'($urandom));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule